// File: doc/BRIEF.md
# Single-Cycle Stochastic Arithmetic Unit

This unit applies one stochastic operation to three 256-bit stochastic bit vectors in a single clock cycle. The three vectors are two operands and a select stream. Every bit position is handled at the same time. The unit then turns the resulting stream back into a binary magnitude by counting its ones. A stream that is generated serially needs one bit per cycle, so a 256-bit stream would take 256 cycles. Here the whole stream is consumed in one step.

A 2-bit opcode picks the operation:
- unipolar product (AND);
- bipolar product (XNOR);
- scaled sum: a per-bit multiplexer steered by the select stream;
- scaled difference: the same multiplexer with operand B inverted.

The unit does not generate the streams. An upstream generator supplies them together with a valid strobe. The unit returns a registered 8-bit count and a matching valid flag.

Top module: `sc_arith_unit`

## Requirements
- R1: With opcode 2'b00, the result stream is the bitwise AND of A and B. The output count is the number of ones in that stream.
- R2: With opcode 2'b01, the result stream is the bitwise XNOR of A and B.
- R3: With opcode 2'b10, each result bit takes the A bit where the S bit is 1 and the B bit where the S bit is 0.
- R4: With opcode 2'b11, each result bit takes the A bit where the S bit is 1 and the inverted B bit where the S bit is 0.
- R5: The ones count is formed at full width, so 0 to 256 is possible. A count of 256 appears on the 8-bit output as 8'hFF. Every count of 255 or less appears unchanged.
- R6: The output valid flag is high in exactly the cycle after a cycle with the input valid strobe high. The output count shown with it is the result of the inputs captured at that strobe.
- R7: While the input valid strobe is low, the output count keeps its last value, whatever the stream and opcode inputs do.
- R8: While reset (active low) is asserted, and after it is released, the output valid flag is 0 and the output count is 0 until the first valid input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs are valid this cycle |
| op_sel | input | 2 | Operation select (R1 to R4) |
| stream_a | input | 256 | Operand stream A |
| stream_b | input | 256 | Operand stream B |
| stream_s | input | 256 | Select stream for add and subtract |
| out_valid | output | 1 | Registered result valid |
| out_count | output | 8 | Registered, saturated ones count |

## Verification
Each opcode is driven with byte-periodic stream patterns, and each pattern gives a count that can be worked out by hand. The select stream and the operand patterns are chosen so that the mask mixes bits from A and B. Swapping the roles of A and B, or dropping the inversion of B, then changes the expected count. For each opcode, one pattern drives the result stream to all ones, which checks that a count of 256 saturates. Other patterns drive the stream to all zeros, which catches a swapped AND/XNOR or a swapped mux polarity. Directed tests cover the reset state, holding the result with scrambled inputs while the strobe is low, back-to-back strobes, and a reset applied while a result is being shown.

// File: rtl/sc_arith_unit.sv
module sc_arith_unit #(
  parameter int STREAM_W = 256,
  parameter int OUT_W    = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [1:0]          op_sel,
  input  logic [STREAM_W-1:0] stream_a,
  input  logic [STREAM_W-1:0] stream_b,
  input  logic [STREAM_W-1:0] stream_s,
  output logic                out_valid,
  output logic [OUT_W-1:0]    out_count
);

  localparam int CNT_W = $clog2(STREAM_W) + 1;
  localparam int NODES = 2 * STREAM_W - 1;
  localparam logic [CNT_W-1:0] SAT_LIM = CNT_W'((1 << OUT_W) - 1);

  localparam logic [1:0] OP_UMUL = 2'b00;
  localparam logic [1:0] OP_BMUL = 2'b01;

  logic [STREAM_W-1:0] opnd_b;
  logic [STREAM_W-1:0] res_bits;
  logic [CNT_W-1:0]    node [NODES];
  logic [OUT_W-1:0]    sat_count;

  assign opnd_b = (op_sel == 2'b11) ? ~stream_b : stream_b;

  always_comb begin
    case (op_sel)
      OP_UMUL: res_bits = stream_a & stream_b;
      OP_BMUL: res_bits = ~(stream_a ^ stream_b);
      default: res_bits = (stream_s & stream_a) | (~stream_s & opnd_b);
    endcase
  end

  genvar gi;
  generate
    for (gi = 0; gi < STREAM_W; gi++) begin : g_leaf
      assign node[STREAM_W-1+gi] = {{(CNT_W-1){1'b0}}, res_bits[gi]};
    end
    for (gi = 0; gi < STREAM_W - 1; gi++) begin : g_sum
      assign node[gi] = node[2*gi+1] + node[2*gi+2];
    end
  endgenerate

  assign sat_count = (node[0] > SAT_LIM) ? {OUT_W{1'b1}} : node[0][OUT_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_count <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_count <= sat_count;
    end
  end

endmodule

// File: rtl/sc_arith_unit_chk.sv
module sc_arith_unit_chk #(
  parameter int STREAM_W = 256,
  parameter int OUT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [1:0]          op_sel,
  input logic [STREAM_W-1:0] stream_a,
  input logic [STREAM_W-1:0] stream_b,
  input logic [STREAM_W-1:0] stream_s,
  input logic                out_valid,
  input logic [OUT_W-1:0]    out_count
);

  assert_valid_follow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_count));

  assert_and_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && stream_a == '0) |=> out_count == '0);

  assert_xnor_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b01 && stream_a == stream_b) |=> out_count == '1);

  assert_mux_pick_a_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b10 && stream_s == '1 && stream_a == '0) |=> out_count == '0);

  assert_sub_invert_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b11 && stream_s == '0 && stream_b == '0) |=> out_count == '1);

  assert_saturate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op_sel == 2'b00 && stream_a == '1 && stream_b == '1) |=> out_count == '1);

endmodule

bind sc_arith_unit sc_arith_unit_chk #(.STREAM_W(STREAM_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
  .stream_a(stream_a), .stream_b(stream_b), .stream_s(stream_s),
  .out_valid(out_valid), .out_count(out_count)
);

// File: tb/sc_arith_unit_test.sv
module sc_arith_unit_test;

  localparam int W = 256;

  typedef struct packed {
    logic [1:0]   op;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] s;
    logic [7:0]   exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{2'b00, {W{1'b1}},     {128{2'b10}},  {W{1'b0}},     8'd128}, // R1
    '{2'b00, {32{8'h0F}},   {32{8'h3C}},   {W{1'b0}},     8'd64},  // R1
    '{2'b00, {W{1'b0}},     {W{1'b1}},     {W{1'b1}},     8'd0},   // R1
    '{2'b01, {32{8'h0F}},   {32{8'h01}},   {W{1'b0}},     8'd160}, // R2
    '{2'b01, {32{8'h5A}},   {32{8'h5A}},   {W{1'b0}},     8'hFF},  // R2 R5
    '{2'b10, {W{1'b1}},     {W{1'b0}},     {128{2'b01}},  8'd128}, // R3
    '{2'b10, {32{8'hFF}},   {32{8'h0F}},   {32{8'hC0}},   8'd192}, // R3
    '{2'b10, {32{8'hF0}},   {32{8'h0F}},   {32{8'hF0}},   8'hFF},  // R3 R5
    '{2'b11, {32{8'hFF}},   {32{8'h0F}},   {32{8'hC0}},   8'd128}, // R4
    '{2'b11, {W{1'b0}},     {W{1'b0}},     {W{1'b0}},     8'hFF},  // R4 R5
    '{2'b11, {W{1'b1}},     {W{1'b1}},     {W{1'b0}},     8'd0}    // R4
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   op_sel = 2'b00;
  logic [W-1:0] stream_a = '0;
  logic [W-1:0] stream_b = '0;
  logic [W-1:0] stream_s = '0;
  logic         out_valid;
  logic [7:0]   out_count;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sc_arith_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
    .stream_a(stream_a), .stream_b(stream_b), .stream_s(stream_s),
    .out_valid(out_valid), .out_count(out_count)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [W-1:0] a,
                       input logic [W-1:0] b, input logic [W-1:0] s, input logic v);
    op_sel = op; stream_a = a; stream_b = b; stream_s = s; in_valid = v;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset valid", 32'(out_valid), 0);
    check("R8 reset count", 32'(out_count), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release valid", 32'(out_valid), 0);
    check("R8 after release count", 32'(out_count), 0);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].a, VECS[i].b, VECS[i].s, 1'b1);
      @(negedge clk);
      check($sformatf("R6 valid vec%0d", i), 32'(out_valid), 1);
      check($sformatf("R1-4/R5 vec%0d op%0d", i, VECS[i].op), 32'(out_count), 32'(VECS[i].exp));
    end

    // R7: hold with scrambled inputs while idle
    drive(2'b01, {32{8'hA5}}, {32{8'h3C}}, {32{8'h96}}, 1'b0);
    @(negedge clk);
    check("R6 idle valid", 32'(out_valid), 0);
    check("R7 hold count", 32'(out_count), 0);
    drive(2'b10, {W{1'b1}}, {W{1'b1}}, {W{1'b1}}, 1'b0);
    @(negedge clk);
    check("R7 hold count 2", 32'(out_count), 0);

    // R6: one pulse, then idle
    drive(2'b00, {32{8'h0F}}, {32{8'h3C}}, '0, 1'b1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 pulse valid", 32'(out_valid), 1);
    check("R1 pulse count", 32'(out_count), 64);
    @(negedge clk);
    check("R6 pulse drop", 32'(out_valid), 0);
    check("R7 pulse held", 32'(out_count), 64);

    // R8: reset while a result is shown
    drive(2'b01, {W{1'b0}}, {W{1'b0}}, '0, 1'b1);
    @(negedge clk);
    check("R5 xnor full", 32'(out_count), 255);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 mid reset valid", 32'(out_valid), 0);
    check("R8 mid reset count", 32'(out_count), 0);
    rst_n = 1'b1;
    in_valid = 1'b0;
    @(negedge clk);
    check("R8 post reset count", 32'(out_count), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule